// File: doc/BRIEF.md
# Memory-Device Refresh Controller

This block is the refresh logic on the device side of a dynamic memory. It samples the row and column strobes on every clock and sorts each row-strobe fall into one of two kinds: a refresh command, when the column strobe went low first, or a normal access, when the row strobe led. A refresh ignores the address pins. It activates the row named by an internal pointer, holds the activate strobe until the array reports that the row has been sensed and restored, and then advances the pointer. No data is ever driven for a refresh.

After each restore the device stays busy for a fixed recovery window and turns away any access in that time. A self-refresh mode lets the device keep its own contents alive while the controller is idle. An internal interval timer issues one refresh per interval, sized so that the whole row range is covered within the retention period. On exit, a refresh that is in flight runs to completion before busy drops. A refresh command that arrives while a refresh is still running is dropped and reported as a protocol error.

Top module: `dram_refresh_ctl`

## Requirements
- R1: A column-strobe fall sampled while the row strobe is high, followed by a row-strobe fall, is a refresh command: row_act_o is high from the clock edge that samples the row strobe low. A row-strobe fall without that prior column fall is a normal access.
- R2: A refresh drives row_addr_o from the internal row pointer, whatever value addr_i holds.
- R3: The row pointer resets to 0 and advances by one on the edge where restore_done_i is sampled during an activate. From ROWS-1 it wraps to 0.
- R4: row_act_o stays high until restore_done_i is sampled. data_oe_o is never high during a refresh.
- R5: busy_o is high from the edge that accepts a refresh through TRFC_CYC cycles after the restore-done edge, and then returns low.
- R6: A normal access that starts while busy_o is high gives a one-cycle acc_rej_o pulse and does not open an access.
- R7: After self_enter_i is sampled, busy_o stays high and a refresh starts every floor(RETENTION_MS*CLK_KHZ/ROWS) cycles. The first one starts that many edges after the enter edge.
- R8: After self_exit_i is sampled, a refresh already in progress completes with its normal busy window, and no further timed refreshes occur.
- R9: A refresh command that arrives while a refresh is in progress starts nothing and does not advance the row pointer. It produces a one-cycle proto_err_o pulse.
- R10: While rst_ni is low, every output is 0.
- R11: An accepted normal access raises acc_open_o and loads row_addr_o from addr_i on the edge that samples the row strobe low. data_oe_o follows one cycle behind a low column strobe. acc_open_o clears on the edge that samples the row strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| addr_i | input | ROW_W | External row address |
| self_enter_i | input | 1 | Request entry into self-refresh |
| self_exit_i | input | 1 | Request exit from self-refresh |
| restore_done_i | input | 1 | Array reports that the row has been sensed and restored |
| row_act_o | output | 1 | Refresh row activate |
| row_addr_o | output | ROW_W | Row being refreshed or accessed |
| busy_o | output | 1 | Refresh or self-refresh in progress |
| acc_open_o | output | 1 | Normal access accepted and open |
| acc_rej_o | output | 1 | Normal access rejected (pulse) |
| data_oe_o | output | 1 | Data output enable for normal access |
| proto_err_o | output | 1 | Refresh command ignored during a refresh (pulse) |

## Verification
All outputs are registered. row_act_o, acc_open_o, acc_rej_o and proto_err_o therefore appear one edge after the edge that samples the deciding strobe level, and data_oe_o appears one edge after that. The bench drives and samples on the falling clock edge and checks each result at the first falling edge after the rising edge that produces it. The busy window is measured by counting falling edges with busy_o high, against the array model's fixed restore latency plus the recovery window. Self-refresh timing is checked at the falling edge just before the expected start and the one just after it.

// File: rtl/drf_pkg.sv
package drf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_HOLD
  } drf_state_e;
endpackage

// File: rtl/drf_strobe_decode.sv
module drf_strobe_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  output logic cbr_req_o,
  output logic acc_req_o
);
  logic ras_q, cas_q, armed_q;
  logic ras_fall, cas_fall;

  assign ras_fall = ras_q & ~ras_ni;
  assign cas_fall = cas_q & ~cas_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      ras_q <= ras_ni;
      cas_q <= cas_ni;
      if (ras_fall || cas_ni)      armed_q <= 1'b0;
      else if (cas_fall && ras_ni) armed_q <= 1'b1;
    end
  end

  assign cbr_req_o = ras_fall & armed_q & ~cas_ni;
  assign acc_req_o = ras_fall & ~(armed_q & ~cas_ni);

  AST_CBR_AFTER_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_req_o |-> $past(!cas_ni)) else $error("cbr without prior cas"); // R1
endmodule

// File: rtl/drf_row_counter.sv
module drf_row_counter #(
  parameter int ROW_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] cnt_o
);
  localparam int ROWS = 1 << ROW_W;
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (inc_i) begin
      if (cnt_o == LAST)    cnt_o <= '0;
      else                  cnt_o <= cnt_o + 1'b1;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o)) else $error("row pointer moved"); // R3
endmodule

// File: rtl/drf_self_timer.sv
module drf_self_timer #(
  parameter int INTERVAL = 390
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam logic [TW-1:0] TOP = TW'(INTERVAL - 1);
  logic [TW-1:0] cnt_q;

  assign tick_o = en_i & (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_TMR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP) else $error("timer out of range"); // R7
endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl
  import drf_pkg::*;
#(
  parameter int ROW_W        = 13,
  parameter int TRFC_CYC     = 13,
  parameter int CLK_KHZ      = 50000,
  parameter int RETENTION_MS = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic [ROW_W-1:0] addr_i,
  input  logic             self_enter_i,
  input  logic             self_exit_i,
  input  logic             restore_done_i,
  output logic             row_act_o,
  output logic [ROW_W-1:0] row_addr_o,
  output logic             busy_o,
  output logic             acc_open_o,
  output logic             acc_rej_o,
  output logic             data_oe_o,
  output logic             proto_err_o
);
  localparam int ROWS     = 1 << ROW_W;
  localparam int SELF_INT = (RETENTION_MS * CLK_KHZ) / ROWS;
  localparam int HW       = $clog2(TRFC_CYC + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(TRFC_CYC - 1);

  drf_state_e       state_q;
  logic [HW-1:0]    hold_q;
  logic             self_q, pend_q;
  logic             cbr_req, acc_req, tick, start_ref, inc;
  logic [ROW_W-1:0] row_cnt;

  drf_strobe_decode u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_ni(ras_ni), .cas_ni(cas_ni),
    .cbr_req_o(cbr_req), .acc_req_o(acc_req)
  );

  drf_row_counter #(.ROW_W(ROW_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc), .cnt_o(row_cnt)
  );

  drf_self_timer #(.INTERVAL(SELF_INT)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(self_q), .tick_o(tick)
  );

  assign inc       = (state_q == ST_ACT) & restore_done_i;
  assign start_ref = (state_q == ST_IDLE) & ~acc_open_o &
                     ((cbr_req & ~self_q) | (self_q & ~self_exit_i & (tick | pend_q)));
  assign row_act_o = (state_q == ST_ACT);
  assign busy_o    = self_q | (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_ref) state_q <= ST_ACT;
        ST_ACT: if (restore_done_i) begin
          state_q <= ST_HOLD;
          hold_q  <= HOLD_LOAD;
        end
        ST_HOLD: begin
          if (hold_q == '0) state_q <= ST_IDLE;
          else              hold_q  <= hold_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // self-refresh mode; exit wins over enter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      self_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (self_exit_i)       self_q <= 1'b0;
      else if (self_enter_i) self_q <= 1'b1;
      if (!self_q || self_exit_i) pend_q <= 1'b0;
      else if (start_ref)         pend_q <= 1'b0;
      else if (tick)              pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_addr_o  <= '0;
      acc_open_o  <= 1'b0;
      acc_rej_o   <= 1'b0;
      data_oe_o   <= 1'b0;
      proto_err_o <= 1'b0;
    end else begin
      acc_rej_o   <= acc_req & busy_o;
      proto_err_o <= cbr_req & (state_q != ST_IDLE);
      data_oe_o   <= acc_open_o & ~cas_ni;
      if (start_ref) row_addr_o <= row_cnt;
      if (acc_req && !busy_o && !acc_open_o) begin
        acc_open_o <= 1'b1;
        row_addr_o <= addr_i;
      end else if (acc_open_o && ras_ni) begin
        acc_open_o <= 1'b0;
      end
    end
  end

  AST_ROW_FROM_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(row_act_o) |-> row_addr_o == row_cnt) else $error("bad refresh row"); // R2
  AST_CNT_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_act_o && restore_done_i) |=> row_cnt != $past(row_cnt)) else $error("no advance"); // R3
  AST_NO_DATA_ON_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_act_o |-> !data_oe_o) else $error("data during refresh"); // R4
  AST_REJ_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rej_o |-> $past(busy_o)) else $error("spurious reject"); // R6
  AST_ERR_IN_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> $past(state_q != ST_IDLE)) else $error("spurious error"); // R9
endmodule

// File: tb/sim_dram_refresh_ctl.sv
`timescale 1ns/1ps
module sim_dram_refresh_ctl;
  localparam int ROW_W  = 4;
  localparam int ROWS   = 16;
  localparam int TRFC   = 5;
  localparam int RD_LAT = 2;
  localparam int INTV   = 62; // 1 ms * 1000 kHz / 16 rows

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ras_ni = 1'b1, cas_ni = 1'b1;
  logic [ROW_W-1:0] addr_i = '0;
  logic self_enter_i = 1'b0, self_exit_i = 1'b0, restore_done_i = 1'b0;
  logic row_act_o, busy_o, acc_open_o, acc_rej_o, data_oe_o, proto_err_o;
  logic [ROW_W-1:0] row_addr_o;

  int total = 0, bad = 0, exp_row = 0, rd_age = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_refresh_ctl #(.ROW_W(ROW_W), .TRFC_CYC(TRFC), .CLK_KHZ(1000), .RETENTION_MS(1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .addr_i(addr_i),
    .self_enter_i(self_enter_i), .self_exit_i(self_exit_i), .restore_done_i(restore_done_i),
    .row_act_o(row_act_o), .row_addr_o(row_addr_o), .busy_o(busy_o), .acc_open_o(acc_open_o),
    .acc_rej_o(acc_rej_o), .data_oe_o(data_oe_o), .proto_err_o(proto_err_o)
  );

  // array model: restore completes RD_LAT cycles after activate
  always @(negedge clk) begin
    if (row_act_o) begin
      restore_done_i = (rd_age == RD_LAT - 1);
      rd_age = rd_age + 1;
    end else begin
      restore_done_i = 1'b0;
      rd_age = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bump();
    exp_row = (exp_row + 1) % ROWS;
  endtask

  // leaves strobes low at the negedge where row_act_o should be visible
  task automatic cbr_start(input logic [ROW_W-1:0] a);
    @(negedge clk); addr_i = a; cas_ni = 1'b0;
    @(negedge clk); ras_ni = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 busy", busy_o, 0);
    chk("R10 row_act", row_act_o, 0);
    chk("R10 acc_open", acc_open_o, 0);
    chk("R10 proto_err", proto_err_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_cbr(input logic [ROW_W-1:0] a);
    int nb = 0, na = 0;
    cbr_start(a);
    chk("R1 row_act", row_act_o, 1);
    chk("R2 row from pointer", row_addr_o, exp_row);
    chk("R4 no data", data_oe_o, 0);
    ras_ni = 1'b1; cas_ni = 1'b1;
    for (int i = 0; i < 200 && busy_o; i++) begin
      nb++;
      if (row_act_o) na++;
      @(negedge clk);
    end
    chk("R5 busy window", nb, RD_LAT + TRFC);
    chk("R4 act until restore", na, RD_LAT);
    bump();
  endtask

  task automatic t_access();
    @(negedge clk); addr_i = 4'd5; ras_ni = 1'b0;
    @(negedge clk);
    chk("R1 access opens", acc_open_o, 1);
    chk("R11 row from addr", row_addr_o, 5);
    chk("R1 no refresh", row_act_o, 0);
    cas_ni = 1'b0;
    @(negedge clk);
    chk("R11 data_oe", data_oe_o, 1);
    ras_ni = 1'b1; cas_ni = 1'b1;
    @(negedge clk);
    chk("R11 access closes", acc_open_o, 0);
    @(negedge clk);
  endtask

  task automatic t_reject();
    cbr_start(4'd9);
    ras_ni = 1'b1; cas_ni = 1'b1;
    @(negedge clk); addr_i = 4'd3; ras_ni = 1'b0;
    @(negedge clk);
    chk("R6 reject pulse", acc_rej_o, 1);
    chk("R6 access not opened", acc_open_o, 0);
    ras_ni = 1'b1;
    @(negedge clk);
    chk("R6 reject one cycle", acc_rej_o, 0);
    wait_idle();
    bump();
  endtask

  task automatic t_error();
    cbr_start(4'd7);
    ras_ni = 1'b1; cas_ni = 1'b1;
    @(negedge clk); cas_ni = 1'b0;
    @(negedge clk); ras_ni = 1'b0;
    @(negedge clk);
    chk("R9 proto_err", proto_err_o, 1);
    ras_ni = 1'b1; cas_ni = 1'b1;
    @(negedge clk);
    chk("R9 proto_err one cycle", proto_err_o, 0);
    wait_idle();
    bump();
    t_cbr(4'd1); // R9 pointer advanced only once
  endtask

  task automatic t_wrap();
    for (int k = 0; k < ROWS + 1; k++) begin
      cbr_start(4'hF);
      chk("R3 pointer sequence", row_addr_o, exp_row);
      ras_ni = 1'b1; cas_ni = 1'b1;
      wait_idle();
      bump();
    end
  endtask

  task automatic t_self();
    int n = 0;
    @(negedge clk); self_enter_i = 1'b1;           // N0
    @(negedge clk); self_enter_i = 1'b0;           // N1
    chk("R7 busy in self", busy_o, 1);
    repeat (INTV - 1) @(negedge clk);              // N_INTV
    chk("R7 not yet", row_act_o, 0);
    chk("R7 busy between", busy_o, 1);
    @(negedge clk);
    chk("R7 first timed refresh", row_act_o, 1);
    chk("R7 first row", row_addr_o, exp_row);
    bump();
    repeat (INTV - 1) @(negedge clk);
    chk("R7 second not yet", row_act_o, 0);
    @(negedge clk);
    chk("R7 second timed refresh", row_act_o, 1);
    chk("R7 second row", row_addr_o, exp_row);
    bump();
    self_exit_i = 1'b1;
    @(negedge clk); self_exit_i = 1'b0;
    chk("R8 busy held during refresh", busy_o, 1);
    wait_idle();
    chk("R8 busy clears", busy_o, 0);
    for (int i = 0; i < 2 * INTV; i++) begin
      if (row_act_o) n++;
      @(negedge clk);
    end
    chk("R8 no timed refresh after exit", n, 0);
    t_cbr(4'd2); // R8 completed refresh advanced pointer
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    t_cbr(4'hA);
    t_access();
    t_reject();
    t_error();
    t_wrap();
    t_self();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule